// File: doc/BRIEF.md
# Strap-Configured Round-Robin PCI Bus Arbiter

This block arbitrates ownership of a PCI bus among several request/grant pairs. Request and grant lines are active low, as on the bus. Four base pairs are always present. Up to three more pairs can be brought in through pins lent by a neighbouring bus. Each lent pair is switched in by its own enable bit. In internal mode the block grants the bus round-robin. When nobody asks for the bus, the grant stays parked on the most recent owner. Ownership moves only at safe points, and a new grant never overlaps the old one.

The block can also step aside for an external arbiter. This choice is made once, at power-up, from the level on base request line 2. The level is captured on the rising edge of power-good while the PLL is still held in reset, so no PCI clock is needed for it. A low level selects external mode: the block then drives no grant at all, so it never preempts a flash transfer that the external arbiter has started. The captured mode is reported on a status output.

Top module: `pciarb`

## Requirements
- R1: The mode strap is the level of `req_n[2]` taken at the rising edge of `pwr_good`, and only when `pll_rst` is high at that edge. A `pwr_good` edge with `pll_rst` low leaves the mode unchanged, and so does any later activity on `req_n[2]`.
- R2: A strap level of 0 gives `ext_mode`=1 (external arbiter). A level of 1 gives `ext_mode`=0 (internal arbiter).
- R3: While `ext_mode` is 1, every bit of `gnt_n` and `alt_gnt_n` stays high, whatever the requests are.
- R4: While `rst_n` is low, all grants are high. The park owner resets to pair 0, which is granted at the first edge with `bus_idle` high.
- R5: At most one grant line is low in any cycle.
- R6: Pair indices are 0–3 for `req_n[3:0]` and 4+k for `alt_req_n[k]`. The next owner is the first requesting pair found by counting upward from the current owner plus one, wrapping from 6 to 0.
- R7: Ownership is handed to another pair only at an edge where `bus_idle` is high or the current owner's request is inactive.
- R8: A handover drops all grants for at least one cycle. The new grant goes low only after an edge at which `bus_idle` was sampled high.
- R9: With no active request, the grant remains on the last owner (parking).
- R10: Pair 4+k takes part only while `borrow_en[k]`=1. Otherwise its request is ignored and `alt_gnt_n[k]` is high.
- R11: Grants are registered. They reflect the inputs sampled at the preceding rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low synchronous reset of the arbitration state |
| pwr_good | input | 1 | Power-good; its rising edge captures the strap |
| pll_rst | input | 1 | PLL reset; the strap is taken only while it is high |
| req_n | input | NB | Base requests, active low; bit 2 doubles as the strap |
| alt_req_n | input | NA | Requests on lent pins, active low |
| borrow_en | input | NA | Per-pair enable for the lent pins |
| bus_idle | input | 1 | High when the bus has no transaction in progress |
| gnt_n | output | NB | Base grants, active low |
| alt_gnt_n | output | NA | Grants on lent pins, active low |
| ext_mode | output | 1 | Mode status: 0 internal arbiter, 1 external arbiter |

## Verification
Grants are due one clock edge after the inputs that caused them. A handover therefore shows as one or more all-high cycles followed by the new grant, and the new grant appears one edge after the first idle sample. The mode status is due straight after the `pwr_good` edge and needs no clock. The bench drives inputs on the falling edge and reads grants on the next falling edge, half a period after the capturing rising edge. The mode is checked a short delay after the `pwr_good` edge, so every sample falls inside the window in which its result is due.

// File: rtl/pciarb_pkg.sv
package pciarb_pkg;
  // Active-low helper values for bus-level lines
  localparam logic LINE_ON  = 1'b0;
  localparam logic LINE_OFF = 1'b1;

  typedef enum logic {
    MODE_INTERNAL = 1'b0,
    MODE_EXTERNAL = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/pciarb_strap.sv
module pciarb_strap
  import pciarb_pkg::*;
(
  input  logic pwr_good,
  input  logic pll_rst,
  input  logic strap_lvl,
  output logic ext_mode
);
  logic strap_q;

  // Captured on the power-good edge itself; no bus clock involved.
  always_ff @(posedge pwr_good) begin
    if (pll_rst) strap_q <= strap_lvl;
  end

  arb_mode_e mode;
  assign mode     = (strap_q == 1'b0) ? MODE_EXTERNAL : MODE_INTERNAL;
  assign ext_mode = (mode == MODE_EXTERNAL);
endmodule

// File: rtl/pciarb_route.sv
module pciarb_route
  import pciarb_pkg::*;
#(
  parameter int NB = 4,
  parameter int NA = 3,
  localparam int N  = NB + NA,
  localparam int IW = $clog2(N)
) (
  input  logic [NB-1:0] req_n,
  input  logic [NA-1:0] alt_req_n,
  input  logic [NA-1:0] borrow_en,
  input  logic          ext_mode,
  input  logic          gnt_on,
  input  logic [IW-1:0] owner,
  output logic [N-1:0]  req,
  output logic [NB-1:0] gnt_n,
  output logic [NA-1:0] alt_gnt_n
);
  genvar i;
  generate
    for (i = 0; i < NB; i++) begin : g_base
      assign req[i]   = (req_n[i] == LINE_ON);
      assign gnt_n[i] = (gnt_on && !ext_mode && owner == IW'(i)) ? LINE_ON : LINE_OFF;
    end
    for (i = 0; i < NA; i++) begin : g_alt
      assign req[NB+i]   = (alt_req_n[i] == LINE_ON) && borrow_en[i];
      assign alt_gnt_n[i] = (gnt_on && !ext_mode && borrow_en[i] &&
                             owner == IW'(NB + i)) ? LINE_ON : LINE_OFF;
    end
  endgenerate
endmodule

// File: rtl/pciarb_core.sv
module pciarb_core #(
  parameter int N  = 7,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_mode,
  input  logic          bus_idle,
  input  logic [N-1:0]  req,
  output logic          gnt_on,
  output logic [IW-1:0] owner
);
  logic          win_valid;
  logic [IW-1:0] win;
  logic          sw_ok;

  // Rotating search that starts one past the owner and ends on the owner.
  always_comb begin
    win_valid = 1'b0;
    win       = owner;
    for (int s = 1; s <= N; s++) begin
      int idx;
      idx = int'(owner) + s;
      if (idx >= N) idx = idx - N;
      if (!win_valid && req[idx]) begin
        win_valid = 1'b1;
        win       = IW'(idx);
      end
    end
  end

  assign sw_ok = bus_idle || !req[owner];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_on <= 1'b0;
      owner  <= '0;
    end else if (ext_mode) begin
      gnt_on <= 1'b0;
    end else if (gnt_on) begin
      if (sw_ok && win_valid && win != owner) begin
        gnt_on <= 1'b0;
        owner  <= win;
      end
    end else if (bus_idle) begin
      gnt_on <= 1'b1;
    end
  end
endmodule

// File: rtl/pciarb.sv
module pciarb #(
  parameter int NB        = 4,
  parameter int NA        = 3,
  parameter int STRAP_IDX = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_good,
  input  logic          pll_rst,
  input  logic [NB-1:0] req_n,
  input  logic [NA-1:0] alt_req_n,
  input  logic [NA-1:0] borrow_en,
  input  logic          bus_idle,
  output logic [NB-1:0] gnt_n,
  output logic [NA-1:0] alt_gnt_n,
  output logic          ext_mode
);
  localparam int N  = NB + NA;
  localparam int IW = $clog2(N);

  logic [N-1:0]  req;
  logic          gnt_on;
  logic [IW-1:0] owner;

  pciarb_strap u_strap (
    .pwr_good (pwr_good),
    .pll_rst  (pll_rst),
    .strap_lvl(req_n[STRAP_IDX]),
    .ext_mode (ext_mode)
  );

  pciarb_route #(.NB(NB), .NA(NA)) u_route (
    .req_n    (req_n),
    .alt_req_n(alt_req_n),
    .borrow_en(borrow_en),
    .ext_mode (ext_mode),
    .gnt_on   (gnt_on),
    .owner    (owner),
    .req      (req),
    .gnt_n    (gnt_n),
    .alt_gnt_n(alt_gnt_n)
  );

  pciarb_core #(.N(N)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .ext_mode(ext_mode),
    .bus_idle(bus_idle),
    .req     (req),
    .gnt_on  (gnt_on),
    .owner   (owner)
  );
endmodule

// File: rtl/pciarb_chk.sv
module pciarb_chk #(
  parameter int NB = 4,
  parameter int NA = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwr_good,
  input logic          bus_idle,
  input logic [NA-1:0] borrow_en,
  input logic [NB-1:0] gnt_n,
  input logic [NA-1:0] alt_gnt_n,
  input logic          ext_mode
);
  logic [NB+NA-1:0] g;
  assign g = {~alt_gnt_n, ~gnt_n};

  // R5
  p_single_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(g));

  // R3
  p_ext_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mode |-> (g == '0));

  // R8: two consecutive non-empty grant cycles must name the same pair
  p_no_direct_swap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (g != '0 && $past(g) != '0) |-> (g == $past(g)));

  // R8: a fresh grant follows an idle sample
  p_grant_after_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (g != '0 && $past(g) == '0 && $stable(borrow_en)) |-> $past(bus_idle));

  // R1
  p_mode_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_good && $past(pwr_good)) |-> $stable(ext_mode));
endmodule

bind pciarb pciarb_chk #(.NB(NB), .NA(NA)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pwr_good (pwr_good),
  .bus_idle (bus_idle),
  .borrow_en(borrow_en),
  .gnt_n    (gnt_n),
  .alt_gnt_n(alt_gnt_n),
  .ext_mode (ext_mode)
);

// File: tb/pciarb_tb.sv
module pciarb_tb;
  localparam int NB = 4;
  localparam int NA = 3;
  localparam int N  = NB + NA;
  localparam int NV = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          pwr_good;
  logic          pll_rst;
  logic [NB-1:0] req_n;
  logic [NA-1:0] alt_req_n;
  logic [NA-1:0] borrow_en;
  logic          bus_idle;
  logic [NB-1:0] gnt_n;
  logic [NA-1:0] alt_gnt_n;
  logic          ext_mode;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pciarb #(.NB(NB), .NA(NA), .STRAP_IDX(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .pll_rst(pll_rst),
    .req_n(req_n), .alt_req_n(alt_req_n), .borrow_en(borrow_en),
    .bus_idle(bus_idle), .gnt_n(gnt_n), .alt_gnt_n(alt_gnt_n),
    .ext_mode(ext_mode)
  );

  // {request mask [17:11] (active high, pair 6..0), borrow_en [10:8], bus_idle [7], expected grants [6:0]}
  localparam logic [17:0] VEC [NV] = '{
    {7'b0000000, 3'b000, 1'b1, 7'b0000001}, // R4 park on pair 0 once idle
    {7'b0000100, 3'b000, 1'b0, 7'b0000000}, // R7 owner idle -> handover gap
    {7'b0000100, 3'b000, 1'b0, 7'b0000000}, // R8 no grant without idle
    {7'b0000100, 3'b000, 1'b1, 7'b0000100}, // R8 grant after idle
    {7'b0001100, 3'b000, 1'b0, 7'b0000100}, // R7 owner busy, bus busy: hold
    {7'b0001100, 3'b000, 1'b1, 7'b0000000}, // R6 move to 3
    {7'b0001101, 3'b000, 1'b1, 7'b0001000}, // R11 grant one edge later
    {7'b0000101, 3'b000, 1'b0, 7'b0000000}, // R6 wrap to 0
    {7'b0000101, 3'b000, 1'b1, 7'b0000001},
    {7'b0000000, 3'b000, 1'b1, 7'b0000001}, // R9 park
    {7'b1010000, 3'b000, 1'b1, 7'b0000001}, // R10 lent requests ignored
    {7'b1010000, 3'b101, 1'b1, 7'b0000000}, // R10 enabled -> pick 4
    {7'b1010000, 3'b101, 1'b1, 7'b0010000},
    {7'b1000000, 3'b101, 1'b0, 7'b0000000}, // R6 4 -> 6
    {7'b1000000, 3'b101, 1'b1, 7'b1000000},
    {7'b1000000, 3'b001, 1'b0, 7'b0000000}, // R10 disable pair 6: grant high
    {7'b0000010, 3'b001, 1'b0, 7'b0000000},
    {7'b0000010, 3'b001, 1'b1, 7'b0000010},
    {7'b0000011, 3'b001, 1'b1, 7'b0000000}, // R6 from 1 wraps to 0
    {7'b0000011, 3'b001, 1'b1, 7'b0000001}
  };

  function automatic logic [N-1:0] seen();
    return {~alt_gnt_n, ~gnt_n};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [N-1:0] r, input logic [NA-1:0] en, input logic idle);
    req_n     = ~r[NB-1:0];
    alt_req_n = ~r[N-1:NB];
    borrow_en = en;
    bus_idle  = idle;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pwr_good = 1'b0; pll_rst = 1'b1;
    drive('0, '0, 1'b1);
    #5 pwr_good = 1'b1;
    #1 check(ext_mode == 1'b0, "R2 strap high gives internal", ext_mode, 0);
    repeat (3) @(negedge clk);
    check(seen() == '0, "R4 grants high in reset", seen(), 0);
    pll_rst = 1'b0;
    rst_n   = 1'b1;

    for (int v = 0; v < NV; v++) begin
      drive(VEC[v][17:11], VEC[v][10:8], VEC[v][7]);
      @(negedge clk);
      check(seen() == VEC[v][6:0], $sformatf("R6 R7 R8 R9 R10 R11 vector %0d", v),
            seen(), VEC[v][6:0]);
      check($countones(seen()) <= 1, "R5 single grant", seen(), 0);
    end

    // External mode through a fresh power-up with strap low
    @(negedge clk);
    rst_n = 1'b0; pll_rst = 1'b1; pwr_good = 1'b0;
    drive('0, '0, 1'b1);
    req_n[2] = 1'b0;
    #1 pwr_good = 1'b1;
    #1 check(ext_mode == 1'b1, "R2 strap low gives external", ext_mode, 1);
    req_n[2] = 1'b1;
    #1 check(ext_mode == 1'b1, "R1 later strap-line change ignored", ext_mode, 1);
    @(negedge clk);
    pll_rst = 1'b0; rst_n = 1'b1;
    for (int c = 0; c < 5; c++) begin
      drive(7'b1111111, 3'b111, 1'b1);
      @(negedge clk);
      check(seen() == '0, "R3 no grant in external mode", seen(), 0);
    end

    // Power-good edge with the PLL out of reset must not recapture
    pwr_good = 1'b0;
    req_n[2] = 1'b1;
    #1 pwr_good = 1'b1;
    #1 check(ext_mode == 1'b1, "R1 capture needs pll_rst high", ext_mode, 1);
    @(negedge clk);
    check(seen() == '0, "R3 still quiet", seen(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule